// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Slave

This block is the slave side of a two-wire serial memory. It holds a 256-byte array and serves a bus master through two oversampled bus inputs (clock line and data line) and one open-drain pull-down enable for the data line. Both lines pass through a synchronizer, and the block finds its bus events by comparing successive samples. A transfer opens with a start condition and then a device address byte. That byte is checked against a fixed family code and three strap inputs. After it comes either a one-byte word address followed by write data, or a stream of read data.

Write data is gathered into an 8-byte page buffer, so a single byte or a partial page works as well as a full page. The buffer is committed only when the master issues a stop. The commit runs inside a write cycle whose length is set by a parameter. For that whole time the block ignores its own device address, so a master finds out that the write is done by polling with address bytes until one is acknowledged. A protect input, sampled at the stop, cancels the commit.

Top module: `ser_eeprom_slave`

## Requirements
- R1: While the clock line is high, a falling data line is a start and a rising data line is a stop. A start in the middle of a byte drops the partial byte and begins a new device address byte.
- R2: A device address byte is acknowledged only if its top four bits are 1010 (MSB first), its next three bits equal `dev_sel_i[2:0]` and no write cycle is running. Its last bit selects read (1) or write (0). After a mismatch, every byte up to the next start is left unacknowledged.
- R3: The acknowledge is a pull-down that is held while the clock is high on the ninth clock of a byte. The pull-down changes only after a falling clock edge, a start or a stop.
- R4: A write is the device address, then a word address byte, then data bytes. A stop commits the buffered bytes to the array.
- R5: Data bytes go to word-address bits [2:0], and this index wraps inside the 8-byte page while bits [7:3] stay fixed. A 9th byte therefore replaces the 1st.
- R6: If `wp_i` is high at the stop, the array is left unchanged and no write cycle starts. The data bytes are still acknowledged, and the next device address is acknowledged at once.
- R7: After a committing stop, the device address is not acknowledged for `WR_CYCLES` clock cycles. After that it is acknowledged again.
- R8: A read returns the byte at the address pointer and then increments the pointer, wrapping from 0xFF to 0x00. A read that is not preceded by a word address continues from the current pointer. After a write, the pointer rests at the page index that follows the last byte.
- R9: The read goes on for as long as the master acknowledges. When the master does not acknowledge, the block releases the data line and stays idle until a start. A stop always returns the block to idle with the line released.
- R10: The block never drives the data line high. It only asserts `sda_pull_o`, and that output is low after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oversampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line sample |
| sda_i | input | 1 | Bus data line sample (wired line) |
| dev_sel_i | input | 3 | Strap bits matched by the device address |
| wp_i | input | 1 | Write protect, high blocks array changes |
| sda_pull_o | output | 1 | High pulls the data line low |

## Verification
Two events can fall in the same cycle: the end of the write cycle and the acknowledge decision for a device address byte. The bench provokes this by polling with write addresses directly after a committing stop, so that some polls land while the timer is still running and a later one lands after it has expired. The result is judged in three ways. At least one poll must go unacknowledged, a poll must be acknowledged before a bounded count is reached, and the data read back afterwards must match the committed bytes. The write-protect case is judged the other way round: the first poll after a blocked stop must be acknowledged.

// File: rtl/eep_pkg.sv
package eep_pkg;
  localparam logic [3:0] DEV_CODE = 4'b1010;
  typedef enum logic [2:0] {ST_IDLE, ST_DEV, ST_ADDR, ST_WDATA, ST_RDATA} state_t;
endpackage

// File: rtl/eep_line_sync.sv
// Synchronizes both bus lines and derives clock edges and start/stop events.
module eep_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic bus_start,
  output logic bus_stop
);
  logic [STAGES-1:0] scl_pipe, sda_pipe;
  logic scl_q, sda_q, scl_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
      scl_q    <= 1'b1;
      sda_q    <= 1'b1;
    end else begin
      scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
      sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
      scl_q    <= scl_s;
      sda_q    <= sda_s;
    end
  end

  assign scl_s     = scl_pipe[STAGES-1];
  assign sda_s     = sda_pipe[STAGES-1];
  assign scl_rise  = scl_s & ~scl_q;
  assign scl_fall  = ~scl_s & scl_q;
  assign bus_start = scl_s & scl_q & sda_q & ~sda_s;
  assign bus_stop  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/eep_wr_timer.sv
// Timed write cycle; the first PAGE cycles stream the page buffer into the array.
module eep_wr_timer #(
  parameter int CYCLES = 1024,
  parameter int PAGE_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  output logic              busy,
  output logic              we,
  output logic [PAGE_W-1:0] idx
);
  localparam int CW = $clog2(CYCLES + 1);
  localparam logic [CW-1:0] CYC_V  = CW'(CYCLES);
  localparam logic [CW-1:0] PAGE_V = CW'(1 << PAGE_W);

  logic [CW-1:0] cnt_q, cnt_d, pos;

  always_comb begin
    cnt_d = cnt_q;
    if (go)                cnt_d = CYC_V;
    else if (cnt_q != '0)  cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign busy = (cnt_q != '0);
  assign pos  = CYC_V - cnt_q;
  assign we   = busy && (pos < PAGE_V);
  assign idx  = pos[PAGE_W-1:0];
endmodule

// File: rtl/eep_array.sv
module eep_array #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/ser_eeprom_slave.sv
module ser_eeprom_slave
  import eep_pkg::*;
#(
  parameter int WR_CYCLES   = 1024,
  parameter int PAGE_W      = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  input  logic [2:0] dev_sel_i,
  input  logic       wp_i,
  output logic       sda_pull_o
);
  localparam int ADDR_W = 8;
  localparam int PAGE   = 1 << PAGE_W;
  localparam logic [PAGE_W-1:0] IDX_ONE = PAGE_W'(1);

  logic [1:0] rst_pipe;
  logic       rst_n_int;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_n_int = rst_pipe[1];

  logic sda_s, scl_rise, scl_fall, bus_start, bus_stop;
  eep_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n_int), .scl_i(scl_i), .sda_i(sda_i), .sda_s(sda_s),
    .scl_rise(scl_rise), .scl_fall(scl_fall), .bus_start(bus_start), .bus_stop(bus_stop)
  );

  state_t             st_q, st_d;
  logic [3:0]         bcnt_q, bcnt_d;
  logic               ack_q, ack_d, oe_q, oe_d, pend_q, pend_d, mack_q, mack_d;
  logic [7:0]         sh_q, sh_d;
  logic [ADDR_W-1:0]  ptr_q, ptr_d;
  logic [7:0]         pbuf_q [PAGE];
  logic [7:0]         pbuf_d [PAGE];
  logic [PAGE-1:0]    mask_q, mask_d;
  logic               wr_go, busy, tmr_we, arr_we;
  logic [PAGE_W-1:0]  tmr_idx;
  logic [7:0]         rd_data;

  eep_wr_timer #(.CYCLES(WR_CYCLES), .PAGE_W(PAGE_W)) u_timer (
    .clk(clk), .rst_n(rst_n_int), .go(wr_go), .busy(busy), .we(tmr_we), .idx(tmr_idx)
  );

  assign arr_we = tmr_we & mask_q[tmr_idx];

  eep_array #(.ADDR_W(ADDR_W), .DATA_W(8)) u_array (
    .clk(clk), .we(arr_we), .waddr({ptr_q[ADDR_W-1:PAGE_W], tmr_idx}),
    .wdata(pbuf_q[tmr_idx]), .raddr(ptr_q), .rdata(rd_data)
  );

  always_comb begin
    st_d = st_q; bcnt_d = bcnt_q; ack_d = ack_q; oe_d = oe_q; sh_d = sh_q;
    ptr_d = ptr_q; pbuf_d = pbuf_q; mask_d = mask_q; pend_d = pend_q;
    mack_d = mack_q; wr_go = 1'b0;
    if (bus_stop) begin
      st_d = ST_IDLE; oe_d = 1'b0; ack_d = 1'b0;
      if (pend_q) begin
        pend_d = 1'b0;
        wr_go  = ~wp_i;
      end
    end else if (bus_start) begin
      st_d = ST_DEV; bcnt_d = '0; ack_d = 1'b0; oe_d = 1'b0;
    end else if (st_q != ST_IDLE) begin
      if (scl_rise) begin
        if (bcnt_q != 4'd8) begin
          bcnt_d = bcnt_q + 4'd1;
          if (st_q != ST_RDATA) sh_d = {sh_q[6:0], sda_s};
        end else if (ack_q) begin
          mack_d = ~sda_s;
        end
      end else if (scl_fall) begin
        if (st_q == ST_RDATA) begin
          if (!ack_q) begin
            if (bcnt_q == 4'd8) begin
              oe_d = 1'b0; ack_d = 1'b1; ptr_d = ptr_q + 1'b1;
            end else if (bcnt_q != 4'd0) begin
              sh_d = {sh_q[6:0], 1'b0}; oe_d = ~sh_q[6];
            end
          end else begin
            ack_d = 1'b0; bcnt_d = '0;
            if (mack_q) begin
              sh_d = rd_data; oe_d = ~rd_data[7];
            end else begin
              st_d = ST_IDLE;
            end
          end
        end else if (bcnt_q == 4'd8) begin
          if (!ack_q) begin
            ack_d = 1'b1; oe_d = 1'b1;
            case (st_q)
              ST_DEV: begin
                if (sh_q[7:1] != {DEV_CODE, dev_sel_i} || busy) begin
                  st_d = ST_IDLE; ack_d = 1'b0; oe_d = 1'b0;
                end
              end
              ST_ADDR: begin
                ptr_d = sh_q; mask_d = '0; pend_d = 1'b0;
              end
              default: begin
                pbuf_d[ptr_q[PAGE_W-1:0]] = sh_q;
                mask_d[ptr_q[PAGE_W-1:0]] = 1'b1;
                ptr_d[PAGE_W-1:0] = ptr_q[PAGE_W-1:0] + IDX_ONE;
                pend_d = 1'b1;
              end
            endcase
          end else begin
            ack_d = 1'b0; oe_d = 1'b0; bcnt_d = '0;
            if (st_q == ST_DEV) begin
              if (sh_q[0]) begin
                st_d = ST_RDATA; sh_d = rd_data; oe_d = ~rd_data[7];
              end else begin
                st_d = ST_ADDR;
              end
            end else begin
              st_d = ST_WDATA;
            end
          end
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n_int) begin
    if (!rst_n_int) begin
      st_q <= ST_IDLE; bcnt_q <= '0; ack_q <= 1'b0; oe_q <= 1'b0; sh_q <= '0;
      ptr_q <= '0; mask_q <= '0; pend_q <= 1'b0; mack_q <= 1'b0;
      for (int i = 0; i < PAGE; i++) pbuf_q[i] <= '0;
    end else begin
      st_q <= st_d; bcnt_q <= bcnt_d; ack_q <= ack_d; oe_q <= oe_d; sh_q <= sh_d;
      ptr_q <= ptr_d; mask_q <= mask_d; pend_q <= pend_d; mack_q <= mack_d;
      pbuf_q <= pbuf_d;
    end
  end

  assign sda_pull_o = oe_q;
endmodule

// File: rtl/eep_checker.sv
module eep_checker
  import eep_pkg::*;
(
  input logic   clk,
  input logic   rst_n,
  input logic   scl_fall,
  input logic   bus_start,
  input logic   bus_stop,
  input logic   sda_pull,
  input logic   busy,
  input logic   arr_we,
  input logic   wp,
  input state_t st
);
  // R3: the pull-down only switches on after a falling clock edge
  assert_pull_on_after_fall_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_pull) |-> $past(scl_fall));
  // R3: the pull-down only releases after a falling edge, a start or a stop
  assert_pull_off_after_event_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sda_pull) |-> $past(scl_fall || bus_start || bus_stop));
  // R9: a stop always returns to idle with the line released
  assert_stop_idles_R9: assert property (@(posedge clk) disable iff (!rst_n)
    bus_stop |=> (st == ST_IDLE && !sda_pull));
  // R6: a write cycle never starts while protect was high
  assert_wp_blocks_cycle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(!wp));
  // R4: the array is written only inside a write cycle
  assert_write_in_cycle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    arr_we |-> busy);
  // R7: no device address acknowledge while the write cycle runs
  assert_no_ack_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_DEV && busy) |-> !sda_pull);
endmodule

bind ser_eeprom_slave eep_checker u_eep_checker (
  .clk(clk), .rst_n(rst_n_int), .scl_fall(scl_fall), .bus_start(bus_start),
  .bus_stop(bus_stop), .sda_pull(sda_pull_o), .busy(busy), .arr_we(arr_we),
  .wp(wp_i), .st(st_q)
);

// File: tb/test_ser_eeprom_slave.sv
module test_ser_eeprom_slave;
  localparam int Q = 8;
  localparam int WRC = 1024;

  logic clk = 1'b0, rst_n = 1'b0, scl_m = 1'b1, sda_m = 1'b1, wp = 1'b0;
  logic [2:0] sel = 3'b101;
  logic pull;
  logic sda_line;
  assign sda_line = sda_m & ~pull;
  always #2.5 clk = ~clk;

  ser_eeprom_slave #(.WR_CYCLES(WRC)) i_ser_eeprom_slave (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
    .dev_sel_i(sel), .wp_i(wp), .sda_pull_o(pull)
  );

  int n_run = 0, n_fail = 0;
  logic [7:0] model [256];
  logic [7:0] bptr = 8'h00;
  logic [7:0] exp_q[$], got_q[$], wq[$];
  string tag_q[$];

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // monitor: pop expected and observed read bytes and compare
  always @(negedge clk) begin : mon
    logic [7:0] g, e;
    string t;
    if (got_q.size() > 0 && exp_q.size() > 0) begin
      g = got_q.pop_front(); e = exp_q.pop_front(); t = tag_q.pop_front();
      check(g == e, t, g, e);
    end
  end

  task automatic qw(input int n); repeat (n) @(negedge clk); endtask
  task automatic bstart(); sda_m = 1; qw(Q); scl_m = 1; qw(Q); sda_m = 0; qw(Q); scl_m = 0; qw(Q); endtask
  task automatic bstop(); sda_m = 0; qw(Q); scl_m = 1; qw(Q); sda_m = 1; qw(Q); endtask
  task automatic wbit(input logic b); sda_m = b; qw(Q); scl_m = 1; qw(2*Q); scl_m = 0; qw(Q); endtask
  task automatic rbit(output logic b); sda_m = 1; qw(Q); scl_m = 1; qw(Q); b = sda_line; qw(Q); scl_m = 0; qw(Q); endtask
  task automatic wbyte(input logic [7:0] v, output bit ack);
    logic a;
    for (int i = 7; i >= 0; i--) wbit(v[i]);
    rbit(a); ack = ~a;
  endtask
  task automatic rbyte(input bit mack, output logic [7:0] v);
    logic b;
    for (int i = 7; i >= 0; i--) begin rbit(b); v[i] = b; end
    wbit(~mack);
  endtask

  // write of wq to address a; checks every acknowledge
  task automatic write_seq(input logic [7:0] a, input string tag);
    bit ack;
    bstart(); wbyte({4'hA, sel, 1'b0}, ack); check(ack, {tag, " dev ack"}, ack, 1);
    wbyte(a, ack); check(ack, {tag, " addr ack"}, ack, 1);
    for (int i = 0; i < wq.size(); i++) begin
      wbyte(wq[i], ack); check(ack, {tag, " data ack"}, ack, 1);
      if (!wp) model[{a[7:3], 3'(a[2:0] + 3'(i))}] = wq[i];
    end
    bptr = {a[7:3], 3'(a[2:0] + 3'(wq.size()))};
    bstop();
  endtask

  // acknowledge polling; returns number of unacknowledged polls
  task automatic poll(output int nacks);
    bit ack;
    nacks = 0;
    for (int k = 0; k < 40; k++) begin
      bstart(); wbyte({4'hA, sel, 1'b0}, ack); bstop();
      if (ack) break;
      nacks++;
    end
  endtask

  // read n bytes, from a if use_a else from current pointer
  task automatic read_seq(input bit use_a, input logic [7:0] a, input int n, input string tag);
    bit ack;
    logic [7:0] v;
    bstart();
    if (use_a) begin
      wbyte({4'hA, sel, 1'b0}, ack); wbyte(a, ack); bptr = a; bstart();
    end
    wbyte({4'hA, sel, 1'b1}, ack); check(ack, {tag, " rd dev ack"}, ack, 1);
    for (int i = 0; i < n; i++) begin
      exp_q.push_back(model[bptr]); tag_q.push_back({tag, " read data"});
      rbyte(i < n - 1, v);
      got_q.push_back(v);
      bptr = bptr + 8'd1;
    end
    // R9: released right after the master's non-acknowledge
    qw(2); check(pull == 1'b0, "R9 released after nack", pull, 0);
    bstop();
  endtask

  initial begin : wd
    repeat (190000) @(posedge clk);
    check(1'b0, "watchdog expired", 0, 1);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin : main
    bit ack;
    int nk;
    qw(4); rst_n = 1; qw(8);
    // R10: reset state releases the line
    check(pull == 1'b0, "R10 reset pull", pull, 0);

    // R2: wrong strap bits, wrong family code, then ignored until start
    bstart(); wbyte({4'hA, 3'b010, 1'b0}, ack); check(!ack, "R2 strap mismatch nack", ack, 0);
    wbyte({4'hA, sel, 1'b0}, ack); check(!ack, "R2 ignored until start", ack, 0);
    bstop();
    bstart(); wbyte({4'hB, sel, 1'b0}, ack); check(!ack, "R2 family code nack", ack, 0);
    bstop();

    // R1: start in the middle of a byte restarts address reception
    bstart(); wbit(1); wbit(0); wbit(1); bstart();
    wbyte({4'hA, sel, 1'b0}, ack); check(ack, "R1 restart after partial byte", ack, 1);
    bstop();

    // R4 R7: byte write, busy window and polling
    wq = {8'hA5}; write_seq(8'h10, "R4");
    poll(nk);
    check(nk >= 1, "R7 nack during write cycle", nk, 1);
    check(nk < 40, "R7 ack after write cycle", nk, 39);
    read_seq(1, 8'h10, 1, "R4");

    // R5: full page, then a wrapping write of 10 bytes
    wq = {8'h00, 8'h01, 8'h02, 8'h03, 8'h04, 8'h05, 8'h06, 8'h07};
    write_seq(8'h38, "R5"); poll(nk);
    wq = {8'h90, 8'h91, 8'h92, 8'h93, 8'h94, 8'h95, 8'h96, 8'h97, 8'h98, 8'h99};
    write_seq(8'h3C, "R5"); poll(nk);
    read_seq(1, 8'h38, 2, "R5 R8");
    // R8: current-address read continues from the pointer
    read_seq(0, 8'h00, 6, "R8 current address");

    // R8: pointer wraps from 0xFF to 0x00
    wq = {8'h5A}; write_seq(8'hFF, "R8"); poll(nk);
    wq = {8'hC3}; write_seq(8'h00, "R8"); poll(nk);
    read_seq(1, 8'hFF, 2, "R8 wrap");

    // R6: protected write acks data but starts no cycle
    wp = 1;
    wq = {8'h00, 8'h11}; write_seq(8'h10, "R6");
    bstart(); wbyte({4'hA, sel, 1'b0}, ack); bstop();
    check(ack, "R6 no write cycle when protected", ack, 1);
    wp = 0;
    read_seq(1, 8'h10, 2, "R6 array unchanged");

    qw(20);
    check(exp_q.size() == 0, "scoreboard drained", exp_q.size(), 0);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule